// File: doc/BRIEF.md
# CAN Receive Acceptance Mask Controller

This block decides where a received CAN frame goes. A frame can go to a receive FIFO, whose acceptance filter table is searched first, or to one of the individual receive mailboxes. For every candidate it picks the acceptance mask from three configuration bits: FIFO enable, individual-mask enable and the filter-element count field. After matching it holds the chosen target. At the start of the intermission that follows the frame, it either commits the store or cancels it.

A frame strobe captures the identifier and the own-transmission flag. On the next clock edge matching completes and the result is latched. A later intermission strobe moves the block into a one-cycle commit window. In that window the store strobe, the target, the matched FIFO element index and the mailbox code update are presented. A protocol error cancels any pending store. Deactivating the target mailbox during the commit window cancels a mailbox store but leaves a FIFO store untouched.

When the FIFO is on, the filter table holds 8 × (count + 1) elements. The table occupies the low mailbox slots 0 up to 6 + 2 × (count + 1) − 1, and those mailboxes do not take part in matching.

Top module: `can_rx_accept`

## Requirements
- R1: A candidate matches when ((frameId XOR filterId) AND mask) is zero. A mask bit of 1 forces equality on that bit, and a mask bit of 0 makes that bit don't-care.
- R2: With cfgFifoEn=0 and cfgIndivMask=0, every mailbox uses mbPubMask, and the per-index masks have no effect.
- R3: With cfgFifoEn=0 and cfgIndivMask=1, mailbox i uses per-index mask i.
- R4: With cfgFifoEn=1 and cfgIndivMask=0, every active FIFO element uses fifoPubMask and mailboxes use mbPubMask. Only elements 0 to 8×(cfgFltCnt+1)−1 are active. Mailboxes with index below 6+2×(cfgFltCnt+1) never match.
- R5: With cfgFifoEn=1 and cfgIndivMask=1, active FIFO element e uses per-index mask e when e < NUM_MB and fifoPubMask otherwise. Mailboxes at or above the FIFO region use their own per-index mask.
- R6: When any active FIFO element matches, the frame goes to the FIFO, and fltHitIdx reports the lowest matching element.
- R7: Otherwise the lowest-index matching empty mailbox is chosen. If no empty mailbox matches, the lowest-index matching full mailbox is chosen. Inactive mailboxes never match.
- R8: With cfgSelfRxDis=1, a frame with frameOwnTx=1 produces no store strobe and no code write. With cfgSelfRxDis=0 such a frame is stored like any other frame.
- R9: A mailbox store is cancelled if the target mailbox is inactive in the commit cycle. A FIFO store is not cancelled by mailbox deactivation.
- R10: protoErr high in the match cycle, the waiting period or the commit cycle cancels the store.
- R11: A mailbox store asserts codeWrEn with codeWrVal 4'h2 (FULL) when the mailbox was empty, or 4'h6 (OVERRUN) when it was full. A FIFO store never asserts codeWrEn.
- R12: The frame is captured at the edge where frameValid is high, and matching completes at the next edge. A later edge with imStart high opens the commit cycle. storeStb is high only in that one cycle and is low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgFifoEn | input | 1 | Receive FIFO enabled |
| cfgIndivMask | input | 1 | Per-index mask selection enabled |
| cfgSelfRxDis | input | 1 | Suppress reception of own frames |
| cfgFltCnt | input | CNT_W | FIFO filter element count field |
| mbPubMask | input | ID_W | Shared mailbox mask |
| fifoPubMask | input | ID_W | FIFO public mask |
| perMask | input | NUM_MB*ID_W | Per-index masks, index i at bits i*ID_W |
| fltId | input | FLT_MAX*ID_W | FIFO filter element identifiers |
| mbId | input | NUM_MB*ID_W | Mailbox identifiers |
| mbActive | input | NUM_MB | Mailbox active flags |
| mbFull | input | NUM_MB | Mailbox holds unread data |
| frameValid | input | 1 | Received frame identifier valid |
| frameId | input | ID_W | Received frame identifier |
| frameOwnTx | input | 1 | Frame was sent by this node |
| protoErr | input | 1 | CAN protocol error strobe |
| imStart | input | 1 | First intermission bit reached |
| storeStb | output | 1 | Commit the store of the frame |
| storeToFifo | output | 1 | Store goes to the FIFO |
| targetIdx | output | MB_IW | Target mailbox index |
| fltHitIdx | output | FLT_IW | Matched FIFO element index |
| codeWrEn | output | 1 | Mailbox code write enable |
| codeWrVal | output | 4 | New mailbox code |

## Verification
Random configurations are applied over all four combinations of FIFO enable and individual masking, with sparse masks and filter identifiers a few bits away from the frame identifier. Together they show whether the right mask source is applied to each candidate and whether the FIFO has precedence over the mailboxes. Directed frames separate individual effects. One case matches only through a don't-care bit. Another matches only beyond the per-index mask range, which tells the FIFO public mask apart from the per-index masks. Others hit a mailbox hidden under the FIFO region, or offer an empty and a full candidate together to show the empty-first rule and the FULL and OVERRUN codes. Own frames, mailbox deactivation and protocol errors in each phase show which late events cancel a mailbox store and which leave a FIFO store in place.

// File: rtl/can_rx_accept_pkg.sv
package can_rx_accept_pkg;

  localparam logic [3:0] CODE_FULL    = 4'h2;
  localparam logic [3:0] CODE_OVERRUN = 4'h6;

  // Strobes from control to datapath
  typedef struct packed {
    logic captureFrame;
    logic latchHit;
  } dpCtrl_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_MATCH  = 2'd1,
    ST_WAIT   = 2'd2,
    ST_COMMIT = 2'd3
  } rxState_t;

endpackage

// File: rtl/can_rx_accept_dp.sv
module can_rx_accept_dp
  import can_rx_accept_pkg::*;
#(
  parameter int ID_W   = 11,
  parameter int NUM_MB = 32,
  parameter int CNT_W  = 4,
  localparam int FLT_MAX = 8 << CNT_W,
  localparam int MB_IW   = $clog2(NUM_MB),
  localparam int FLT_IW  = $clog2(FLT_MAX)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  dpCtrl_t                 ctrl,
  input  logic                    cfgFifoEn,
  input  logic                    cfgIndivMask,
  input  logic [CNT_W-1:0]        cfgFltCnt,
  input  logic [ID_W-1:0]         mbPubMask,
  input  logic [ID_W-1:0]         fifoPubMask,
  input  logic [NUM_MB*ID_W-1:0]  perMask,
  input  logic [FLT_MAX*ID_W-1:0] fltId,
  input  logic [NUM_MB*ID_W-1:0]  mbId,
  input  logic [NUM_MB-1:0]       mbActive,
  input  logic [NUM_MB-1:0]       mbFull,
  input  logic [ID_W-1:0]         frameId,
  output logic                    hitNow,
  output logic                    hitFifoQ,
  output logic [MB_IW-1:0]        hitMbIdxQ,
  output logic [FLT_IW-1:0]       hitFltIdxQ,
  output logic                    hitFullQ,
  output logic                    tgtActive
);

  logic [ID_W-1:0]    capId;
  logic [FLT_MAX-1:0] fltHit;
  logic [NUM_MB-1:0]  mbHit;
  int                 nFlt;
  int                 regionMbs;

  assign nFlt      = (int'(cfgFltCnt) + 1) * 8;
  assign regionMbs = 6 + 2 * (int'(cfgFltCnt) + 1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) capId <= '0;
    else if (ctrl.captureFrame) capId <= frameId;
  end

  // FIFO filter elements: mask source depends on index and mode
  for (genvar e = 0; e < FLT_MAX; e++) begin : g_flt
    logic [ID_W-1:0] effMask;
    if (e < NUM_MB) begin : g_ind
      always_comb begin
        if (cfgIndivMask && (e < nFlt)) effMask = perMask[e*ID_W +: ID_W];
        else effMask = fifoPubMask;
      end
    end else begin : g_pub
      assign effMask = fifoPubMask;
    end
    assign fltHit[e] = cfgFifoEn && (e < nFlt) &&
                       (((capId ^ fltId[e*ID_W +: ID_W]) & effMask) == '0);
  end

  // Mailboxes: shared or per-index mask, FIFO region excluded
  for (genvar i = 0; i < NUM_MB; i++) begin : g_mb
    logic [ID_W-1:0] effMask;
    logic            elig;
    assign effMask  = cfgIndivMask ? perMask[i*ID_W +: ID_W] : mbPubMask;
    assign elig     = mbActive[i] && (!cfgFifoEn || (i >= regionMbs));
    assign mbHit[i] = elig && (((capId ^ mbId[i*ID_W +: ID_W]) & effMask) == '0);
  end

  logic [NUM_MB-1:0] emptyHit;
  logic [NUM_MB-1:0] fullHit;
  logic [FLT_IW-1:0] fltIdxN;
  logic [MB_IW-1:0]  emptyIdx;
  logic [MB_IW-1:0]  fullIdx;
  logic              fifoAny;

  assign emptyHit = mbHit & ~mbFull;
  assign fullHit  = mbHit & mbFull;
  assign fifoAny  = |fltHit;

  // Lowest index wins: scan downward so the last write is the lowest
  always_comb begin
    fltIdxN = '0;
    for (int e = FLT_MAX - 1; e >= 0; e--) begin
      if (fltHit[e]) fltIdxN = FLT_IW'(e);
    end
  end

  always_comb begin
    emptyIdx = '0;
    fullIdx  = '0;
    for (int i = NUM_MB - 1; i >= 0; i--) begin
      if (emptyHit[i]) emptyIdx = MB_IW'(i);
      if (fullHit[i])  fullIdx  = MB_IW'(i);
    end
  end

  assign hitNow = fifoAny || (|mbHit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hitFifoQ   <= 1'b0;
      hitMbIdxQ  <= '0;
      hitFltIdxQ <= '0;
      hitFullQ   <= 1'b0;
    end else if (ctrl.latchHit) begin
      hitFifoQ   <= fifoAny;
      hitFltIdxQ <= fltIdxN;
      hitMbIdxQ  <= (|emptyHit) ? emptyIdx : fullIdx;
      hitFullQ   <= !fifoAny && !(|emptyHit);
    end
  end

  assign tgtActive = mbActive[hitMbIdxQ];

endmodule

// File: rtl/can_rx_accept_ctl.sv
module can_rx_accept_ctl
  import can_rx_accept_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    frameValid,
  input  logic    frameOwnTx,
  input  logic    cfgSelfRxDis,
  input  logic    protoErr,
  input  logic    imStart,
  input  logic    hitNow,
  input  logic    hitFifoQ,
  input  logic    tgtActive,
  output dpCtrl_t ctrl,
  output logic    storeStb
);

  rxState_t state;
  rxState_t stateN;
  logic     ownQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      ownQ  <= 1'b0;
    end else begin
      state <= stateN;
      if (ctrl.captureFrame) ownQ <= frameOwnTx;
    end
  end

  always_comb begin
    stateN = state;
    unique case (state)
      ST_IDLE:   if (frameValid) stateN = ST_MATCH;
      ST_MATCH: begin
        if (protoErr || !hitNow || (cfgSelfRxDis && ownQ)) stateN = ST_IDLE;
        else stateN = ST_WAIT;
      end
      ST_WAIT: begin
        if (protoErr) stateN = ST_IDLE;
        else if (imStart) stateN = ST_COMMIT;
      end
      ST_COMMIT: stateN = ST_IDLE;
      default:   stateN = ST_IDLE;
    endcase
  end

  always_comb begin
    ctrl.captureFrame = (state == ST_IDLE) && frameValid;
    ctrl.latchHit     = (state == ST_MATCH);
  end

  // Late cancel: error always, deactivation only for a mailbox target
  assign storeStb = (state == ST_COMMIT) && !protoErr && (hitFifoQ || tgtActive);

endmodule

// File: rtl/can_rx_accept.sv
module can_rx_accept
  import can_rx_accept_pkg::*;
#(
  parameter int ID_W   = 11,
  parameter int NUM_MB = 32,
  parameter int CNT_W  = 4,
  localparam int FLT_MAX = 8 << CNT_W,
  localparam int MB_IW   = $clog2(NUM_MB),
  localparam int FLT_IW  = $clog2(FLT_MAX)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cfgFifoEn,
  input  logic                    cfgIndivMask,
  input  logic                    cfgSelfRxDis,
  input  logic [CNT_W-1:0]        cfgFltCnt,
  input  logic [ID_W-1:0]         mbPubMask,
  input  logic [ID_W-1:0]         fifoPubMask,
  input  logic [NUM_MB*ID_W-1:0]  perMask,
  input  logic [FLT_MAX*ID_W-1:0] fltId,
  input  logic [NUM_MB*ID_W-1:0]  mbId,
  input  logic [NUM_MB-1:0]       mbActive,
  input  logic [NUM_MB-1:0]       mbFull,
  input  logic                    frameValid,
  input  logic [ID_W-1:0]         frameId,
  input  logic                    frameOwnTx,
  input  logic                    protoErr,
  input  logic                    imStart,
  output logic                    storeStb,
  output logic                    storeToFifo,
  output logic [MB_IW-1:0]        targetIdx,
  output logic [FLT_IW-1:0]       fltHitIdx,
  output logic                    codeWrEn,
  output logic [3:0]              codeWrVal
);

  dpCtrl_t           ctrl;
  logic              hitNow;
  logic              hitFifoQ;
  logic [MB_IW-1:0]  hitMbIdxQ;
  logic [FLT_IW-1:0] hitFltIdxQ;
  logic              hitFullQ;
  logic              tgtActive;

  can_rx_accept_dp #(.ID_W(ID_W), .NUM_MB(NUM_MB), .CNT_W(CNT_W)) i_dp (
    .clk, .rstN, .ctrl,
    .cfgFifoEn, .cfgIndivMask, .cfgFltCnt,
    .mbPubMask, .fifoPubMask, .perMask, .fltId, .mbId,
    .mbActive, .mbFull, .frameId,
    .hitNow, .hitFifoQ, .hitMbIdxQ, .hitFltIdxQ, .hitFullQ, .tgtActive
  );

  can_rx_accept_ctl i_ctl (
    .clk, .rstN, .frameValid, .frameOwnTx, .cfgSelfRxDis,
    .protoErr, .imStart, .hitNow, .hitFifoQ, .tgtActive,
    .ctrl, .storeStb
  );

  assign storeToFifo = storeStb && hitFifoQ;
  assign targetIdx   = hitMbIdxQ;
  assign fltHitIdx   = hitFltIdxQ;
  assign codeWrEn    = storeStb && !hitFifoQ;
  assign codeWrVal   = hitFullQ ? CODE_OVERRUN : CODE_FULL;

endmodule

// File: rtl/can_rx_accept_chk.sv
module can_rx_accept_chk #(
  parameter int ID_W   = 11,
  parameter int NUM_MB = 32,
  parameter int CNT_W  = 4,
  localparam int FLT_MAX = 8 << CNT_W,
  localparam int MB_IW   = $clog2(NUM_MB),
  localparam int FLT_IW  = $clog2(FLT_MAX)
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgFifoEn,
  input logic [CNT_W-1:0]  cfgFltCnt,
  input logic [NUM_MB-1:0] mbActive,
  input logic              protoErr,
  input logic              imStart,
  input logic              storeStb,
  input logic              storeToFifo,
  input logic [MB_IW-1:0]  targetIdx,
  input logic [FLT_IW-1:0] fltHitIdx
);

  a_r10_err_blocks_store: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |-> !storeStb);

  a_r9_mb_target_active: assert property (@(posedge clk) disable iff (!rstN)
    (storeStb && !storeToFifo) |-> mbActive[targetIdx]);

  a_r12_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    storeStb |=> !storeStb);

  a_r12_after_im: assert property (@(posedge clk) disable iff (!rstN)
    storeStb |-> $past(imStart));

  a_r4_fifo_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    storeToFifo |-> cfgFifoEn);

  a_r4_flt_in_table: assert property (@(posedge clk) disable iff (!rstN)
    storeToFifo |-> (int'(fltHitIdx) < (int'(cfgFltCnt) + 1) * 8));

  a_r4_mb_outside_region: assert property (@(posedge clk) disable iff (!rstN)
    (storeStb && !storeToFifo && cfgFifoEn) |->
      (int'(targetIdx) >= 6 + 2 * (int'(cfgFltCnt) + 1)));

endmodule

bind can_rx_accept can_rx_accept_chk #(.ID_W(ID_W), .NUM_MB(NUM_MB), .CNT_W(CNT_W)) i_chk (.*);

// File: tb/test_can_rx_accept.sv
`timescale 1ns/1ps
module test_can_rx_accept;

  localparam int ID_W    = 11;
  localparam int NUM_MB  = 32;
  localparam int CNT_W   = 4;
  localparam int FLT_MAX = 8 << CNT_W;
  localparam int MB_IW   = $clog2(NUM_MB);
  localparam int FLT_IW  = $clog2(FLT_MAX);
  localparam logic [ID_W-1:0] BASE = 11'h2A5;

  typedef struct packed {
    logic              v;
    logic              toFifo;
    logic [MB_IW-1:0]  mb;
    logic [FLT_IW-1:0] flt;
    logic              full;
  } exp_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic                    cfgFifoEn = 0, cfgIndivMask = 0, cfgSelfRxDis = 0;
  logic [CNT_W-1:0]        cfgFltCnt = '0;
  logic [ID_W-1:0]         mbPubMask = '1, fifoPubMask = '1;
  logic [ID_W-1:0]         perM   [NUM_MB];
  logic [ID_W-1:0]         mbIdA  [NUM_MB];
  logic [ID_W-1:0]         fltIdA [FLT_MAX];
  logic [NUM_MB*ID_W-1:0]  perMaskF, mbIdF;
  logic [FLT_MAX*ID_W-1:0] fltIdF;
  logic [NUM_MB-1:0]       mbActive = '1, mbFull = '0;
  logic                    frameValid = 0, frameOwnTx = 0, protoErr = 0, imStart = 0;
  logic [ID_W-1:0]         frameId = '0;
  logic                    storeStb, storeToFifo, codeWrEn;
  logic [MB_IW-1:0]        targetIdx;
  logic [FLT_IW-1:0]       fltHitIdx;
  logic [3:0]              codeWrVal;

  always_comb begin
    for (int i = 0; i < NUM_MB; i++) begin
      perMaskF[i*ID_W +: ID_W] = perM[i];
      mbIdF[i*ID_W +: ID_W]    = mbIdA[i];
    end
    for (int e = 0; e < FLT_MAX; e++) fltIdF[e*ID_W +: ID_W] = fltIdA[e];
  end

  can_rx_accept #(.ID_W(ID_W), .NUM_MB(NUM_MB), .CNT_W(CNT_W)) i_can_rx_accept (
    .clk, .rstN, .cfgFifoEn, .cfgIndivMask, .cfgSelfRxDis, .cfgFltCnt,
    .mbPubMask, .fifoPubMask, .perMask(perMaskF), .fltId(fltIdF), .mbId(mbIdF),
    .mbActive, .mbFull, .frameValid, .frameId, .frameOwnTx, .protoErr, .imStart,
    .storeStb, .storeToFifo, .targetIdx, .fltHitIdx, .codeWrEn, .codeWrVal
  );

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  task automatic check(input string tag, input bit ok, input logic [31:0] got, input logic [31:0] want);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", tag, got, want);
    end
  endtask

  // Reference per the requirements (R1..R7)
  function automatic exp_t model(input logic [ID_W-1:0] id);
    exp_t r;
    int nf, reg0;
    logic [ID_W-1:0] m;
    bit gotEmpty, gotFull;
    logic [MB_IW-1:0] fi;
    r = '0;
    nf = (int'(cfgFltCnt) + 1) * 8;
    reg0 = 6 + 2 * (int'(cfgFltCnt) + 1);
    if (cfgFifoEn) begin
      for (int e = nf - 1; e >= 0; e--) begin
        m = (cfgIndivMask && e < NUM_MB) ? perM[e] : fifoPubMask;
        if (((id ^ fltIdA[e]) & m) == '0) begin
          r.v = 1; r.toFifo = 1; r.flt = FLT_IW'(e);
        end
      end
      if (r.v) return r;
    end
    gotEmpty = 0; gotFull = 0; fi = '0;
    for (int i = 0; i < NUM_MB; i++) begin
      m = cfgIndivMask ? perM[i] : mbPubMask;
      if (mbActive[i] && (!cfgFifoEn || i >= reg0) && (((id ^ mbIdA[i]) & m) == '0)) begin
        if (!mbFull[i] && !gotEmpty) begin gotEmpty = 1; r.mb = MB_IW'(i); end
        if (mbFull[i] && !gotFull) begin gotFull = 1; fi = MB_IW'(i); end
      end
    end
    if (gotEmpty) begin r.v = 1; r.full = 0; end
    else if (gotFull) begin r.v = 1; r.full = 1; r.mb = fi; end
    return r;
  endfunction

  task automatic runFrame(input string tag, input logic [ID_W-1:0] id, input bit own,
                          input bit deact, input bit errWait, input bit errCommit);
    exp_t ex;
    bit expStore;
    logic [NUM_MB-1:0] saveAct;
    ex = model(id);
    if (cfgSelfRxDis && own) ex.v = 0;
    expStore = ex.v && !errWait && !errCommit && (ex.toFifo || !deact);
    @(negedge clk);
    frameValid = 1; frameId = id; frameOwnTx = own;
    @(negedge clk);
    frameValid = 0;
    @(negedge clk);
    check({tag, " R12 no early store"}, storeStb == 0, storeStb, 0);
    imStart = 1; protoErr = errWait;
    @(negedge clk);
    imStart = 0; protoErr = errCommit;
    saveAct = mbActive;
    if (deact) mbActive = '0;
    #1;
    if (!expStore) begin
      check(tag, storeStb == 0 && codeWrEn == 0, {storeStb, codeWrEn}, 0);
    end else if (ex.toFifo) begin
      check(tag, storeStb && storeToFifo && !codeWrEn && fltHitIdx == ex.flt,
            {storeStb, storeToFifo, codeWrEn, 5'b0, 8'(fltHitIdx)},
            {3'b110, 5'b0, 8'(ex.flt)});
    end else begin
      check(tag, storeStb && !storeToFifo && codeWrEn && targetIdx == ex.mb &&
            codeWrVal == (ex.full ? 4'h6 : 4'h2),
            {storeStb, storeToFifo, codeWrEn, 1'b0, codeWrVal, 8'(targetIdx)},
            {3'b101, 1'b0, (ex.full ? 4'h6 : 4'h2), 8'(ex.mb)});
    end
    @(negedge clk);
    mbActive = saveAct; protoErr = 0;
    check({tag, " R12 one-cycle strobe"}, storeStb == 0, storeStb, 0);
  endtask

  task automatic clearCfg();
    cfgFifoEn = 0; cfgIndivMask = 0; cfgSelfRxDis = 0; cfgFltCnt = '0;
    mbPubMask = '1; fifoPubMask = '1;
    for (int i = 0; i < NUM_MB; i++) begin perM[i] = '1; mbIdA[i] = ~BASE; end
    for (int e = 0; e < FLT_MAX; e++) fltIdA[e] = ~BASE;
    mbActive = '1; mbFull = '0;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    clearCfg();
    repeat (3) @(negedge clk);
    check("R12 reset idle", storeStb == 0 && codeWrEn == 0, {storeStb, codeWrEn}, 0);
    rstN = 1;
    @(negedge clk);

    // R1: bits outside mask are don't-care
    clearCfg(); mbActive = '0; mbActive[3] = 1;
    mbPubMask = 11'h0F0; mbIdA[3] = BASE ^ 11'h00F;
    runFrame("R1 dont-care bits", BASE, 0, 0, 0, 0);
    mbPubMask = 11'h0FF;
    runFrame("R1 masked bit differs", BASE, 0, 0, 0, 0);

    // R2: shared mask, per-index ignored
    clearCfg(); mbIdA[12] = BASE ^ 11'h100; mbPubMask = 11'h6FF;
    runFrame("R2 shared mask", BASE, 0, 0, 0, 0);

    // R3: per-index mask used
    clearCfg(); cfgIndivMask = 1; mbIdA[7] = BASE ^ 11'h010; perM[7] = 11'h7EF;
    mbIdA[4] = BASE ^ 11'h010; mbPubMask = 11'h7EF;
    runFrame("R3 per-index mask", BASE, 0, 0, 0, 0);

    // R4: FIFO region hides low mailboxes
    clearCfg(); cfgFifoEn = 1; mbIdA[4] = BASE; mbIdA[20] = BASE;
    runFrame("R4 region excluded", BASE, 0, 0, 0, 0);
    fltIdA[9] = BASE;
    runFrame("R4 element beyond count", BASE, 0, 0, 0, 0);
    fifoPubMask = 11'h7F0; fltIdA[5] = BASE ^ 11'h003;
    runFrame("R4 fifo public mask", BASE, 0, 0, 0, 0);

    // R5: elements past per-index range use FIFO public mask
    clearCfg(); cfgFifoEn = 1; cfgIndivMask = 1; cfgFltCnt = 4;
    fifoPubMask = 11'h3FF; fltIdA[35] = BASE ^ 11'h400;
    runFrame("R5 element 35 public", BASE, 0, 0, 0, 0);
    fltIdA[10] = BASE ^ 11'h001; perM[10] = 11'h7FE;
    runFrame("R5 element 10 per-index", BASE, 0, 0, 0, 0);

    // R6: FIFO before mailboxes, lowest element
    clearCfg(); cfgFifoEn = 1; fltIdA[3] = BASE; fltIdA[6] = BASE; mbIdA[25] = BASE;
    runFrame("R6 fifo lowest element", BASE, 0, 0, 0, 0);

    // R7/R11: empty preferred, then full with overrun code
    clearCfg(); mbIdA[2] = BASE; mbIdA[5] = BASE; mbIdA[9] = BASE; mbFull[2] = 1;
    runFrame("R7 empty preferred", BASE, 0, 0, 0, 0);
    mbFull[5] = 1; mbFull[9] = 1;
    runFrame("R11 overrun code", BASE, 0, 0, 0, 0);
    mbActive[2] = 0;
    runFrame("R7 inactive skipped", BASE, 0, 0, 0, 0);

    // R8: self reception
    clearCfg(); cfgSelfRxDis = 1; mbIdA[14] = BASE;
    runFrame("R8 own frame dropped", BASE, 1, 0, 0, 0);
    runFrame("R8 foreign frame kept", BASE, 0, 0, 0, 0);
    cfgSelfRxDis = 0;
    runFrame("R8 own frame allowed", BASE, 1, 0, 0, 0);

    // R9: late deactivation
    runFrame("R9 mailbox cancelled", BASE, 0, 1, 0, 0);
    cfgFifoEn = 1; fltIdA[0] = BASE;
    runFrame("R9 fifo not cancelled", BASE, 0, 1, 0, 0);

    // R10: protocol error in wait and commit
    runFrame("R10 error in wait", BASE, 0, 0, 1, 0);
    runFrame("R10 error in commit", BASE, 0, 0, 0, 1);
    cfgFifoEn = 0;
    runFrame("R10 mailbox error in commit", BASE, 0, 0, 0, 1);

    // Random mix over all mask modes
    for (int n = 0; n < 400; n++) begin
      logic [ID_W-1:0] id;
      string tag;
      id = ID_W'($urandom);
      cfgFifoEn    = 1'($urandom);
      cfgIndivMask = 1'($urandom);
      cfgSelfRxDis = 1'($urandom);
      cfgFltCnt    = CNT_W'($urandom % 4);
      mbPubMask    = ID_W'($urandom & $urandom);
      fifoPubMask  = ID_W'($urandom | $urandom);
      for (int i = 0; i < NUM_MB; i++) begin
        perM[i]  = (cfgFifoEn && !cfgIndivMask) ? fifoPubMask : ID_W'($urandom & $urandom);
        mbIdA[i] = id ^ ID_W'($urandom & $urandom & $urandom);
      end
      for (int e = 0; e < FLT_MAX; e++) fltIdA[e] = id ^ ID_W'($urandom & $urandom);
      mbActive = NUM_MB'($urandom | $urandom);
      mbFull   = NUM_MB'($urandom);
      if (!cfgFifoEn) tag = cfgIndivMask ? "R3 random" : "R2 random";
      else tag = cfgIndivMask ? "R5 random" : "R4 random";
      runFrame(tag, id, ($urandom % 4) == 0, ($urandom % 8) == 0,
               ($urandom % 16) == 0, ($urandom % 16) == 0);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule